// File: doc/BRIEF.md
# Three-Plane Character Cell Raster Generator

This block produces the raster for a text-style display built from 8x10 pixel character cells. It holds its own pixel, column and line counters and generates horizontal sync, vertical sync and display-enable from them. For every visible cell it reads a tile entry from video RAM and uses the low byte of that entry as the character code. It then reads one row byte of that character from each of three equal plane regions of a graphics ROM. The three bytes go into three shift registers, and one pixel per clock leaves the block as a 3-bit colour index.

Both memories are read through simple address/data ports with combinational (same-cycle) read data. The block fetches the next cell while the current one is being shifted out, so consecutive cells join with no gap. Everything outside the 74x24-cell visible window is blanked. The default geometry gives a frame of 88x27 cells (704 clocks by 270 lines).

Top module: `tile_raster_gen`

## Requirements
- R1: While `rst` is high, `pixColour`, `dispEn`, `hsync` and `vsync` are all 0. Pixel 0 of line 0 of the first frame appears after the 8th rising edge following the release of reset.
- R2: A line lasts 704 pixel clocks (88 cells of 8 pixels), a frame lasts 270 lines, and frames repeat with no gap.
- R3: Pixels of a cell leave the block with row-byte bit 7 first and bit 0 last. Bit i of `pixColour` is taken from plane i (i = 0, 1, 2).
- R4: Plane p's byte for character n, row r is read at ROM address p*16384 + n*16 + r, with r from 0 to 9. Rows 10 to 15 of each 16-byte character slot never reach the output.
- R5: `hsync` is high during cell columns 75 to 85 of every line, which is 11 cells or 88 clocks, and low elsewhere.
- R6: `vsync` is high for the whole of lines 250 to 253, which is 4 lines, and low elsewhere.
- R7: `dispEn` is high only for columns 0 to 73 on lines 0 to 239. When it is low, `pixColour` is 0.
- R8: The visible cell at character row y, column x takes its code from video RAM entry y*74 + x. Only bits 7:0 of the entry are used, and bits 15:8 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vramAddr | output | 11 | Video RAM entry address |
| vramData | input | 16 | Video RAM entry read data (same cycle) |
| romAddr | output | 16 | Graphics ROM byte address |
| romData | input | 8 | Graphics ROM read data (same cycle) |
| pixColour | output | 3 | Pixel colour index, plane i on bit i |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| dispEn | output | 1 | High on visible pixels |

## Verification
The bench fills video RAM with a varied code pattern whose high bytes carry noise, and fills the ROM with a hashed pattern. Against this it places a hand-built character with asymmetric plane bytes and 0xFF in its unused rows. This character tells bit order and plane-to-colour-bit mapping apart from simple inversions, and shows whether a fetch strays into rows 10 to 15. An all-ones cell next to it separates gap and shift-order faults from addressing faults. The full first frame is compared on every clock with a behavioural pixel model. Explicit counts of sync widths and line spacing separate timing faults from data-path faults.

// File: rtl/tile_raster_pkg.sv
`timescale 1ns/1ps
package tile_raster_pkg;
  // strobes from the raster control to the plane datapath
  typedef struct packed {
    logic       grabCode;   // latch tile code of the next cell
    logic [1:0] grabPlane;  // latch plane 0 / plane 1 row byte
    logic       loadAll;    // plane 2 byte valid, load all shifters
    logic [1:0] plane;      // plane index selecting the ROM region
  } fetch_strobe_t;
endpackage

// File: rtl/raster_ctrl.sv
`timescale 1ns/1ps
module raster_ctrl
  import tile_raster_pkg::*;
#(
  parameter int CELL_W   = 8,
  parameter int CELL_H   = 10,
  parameter int VIS_COLS = 74,
  parameter int VIS_ROWS = 24,
  parameter int TOT_COLS = 88,
  parameter int TOT_ROWS = 27,
  parameter int HS_COL   = 75,
  parameter int HS_CHARS = 11,
  parameter int VS_ROW   = 25,
  parameter int VS_LINES = 4,
  localparam int SUB_W   = $clog2(CELL_W),
  localparam int COL_W   = $clog2(TOT_COLS),
  localparam int SCAN_W  = $clog2(CELL_H),
  localparam int ROW_W   = $clog2(TOT_ROWS),
  localparam int VRAM_AW = $clog2(VIS_COLS * VIS_ROWS)
) (
  input  logic               clk,
  input  logic               rst,
  output logic [VRAM_AW-1:0] vramAddr,
  output fetch_strobe_t      strb,
  output logic [SCAN_W-1:0]  rowSel,
  output logic               hsync,
  output logic               vsync,
  output logic               dispEn
);
  localparam logic [SUB_W-1:0]  LAST_SUB  = SUB_W'(CELL_W - 1);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(TOT_COLS - 1);
  localparam logic [SCAN_W-1:0] LAST_SCAN = SCAN_W'(CELL_H - 1);
  localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(TOT_ROWS - 1);
  localparam logic [SUB_W-1:0]  SLOT_CODE = SUB_W'(CELL_W - 4);
  localparam logic [SUB_W-1:0]  SLOT_P0   = SUB_W'(CELL_W - 3);
  localparam logic [SUB_W-1:0]  SLOT_P1   = SUB_W'(CELL_W - 2);

  logic [SUB_W-1:0]  sub;
  logic [COL_W-1:0]  col, nCol;
  logic [SCAN_W-1:0] scan, nScan;
  logic [ROW_W-1:0]  crow, nCrow;
  logic              nextVis;

  // coordinates of the cell that follows the current one
  always_comb begin
    nCol  = col + 1'b1;
    nScan = scan;
    nCrow = crow;
    if (col == LAST_COL) begin
      nCol = '0;
      if (scan == LAST_SCAN) begin
        nScan = '0;
        nCrow = (crow == LAST_ROW) ? '0 : crow + 1'b1;
      end else begin
        nScan = scan + 1'b1;
      end
    end
  end

  // reset parks the raster in the final blanked cell of the frame
  always_ff @(posedge clk) begin
    if (rst) begin
      sub  <= '0;
      col  <= LAST_COL;
      scan <= LAST_SCAN;
      crow <= LAST_ROW;
    end else if (sub == LAST_SUB) begin
      sub  <= '0;
      col  <= nCol;
      scan <= nScan;
      crow <= nCrow;
    end else begin
      sub <= sub + 1'b1;
    end
  end

  assign nextVis  = (nCol < COL_W'(VIS_COLS)) && (nCrow < ROW_W'(VIS_ROWS));
  assign vramAddr = nextVis ? (VRAM_AW'(nCrow) * VRAM_AW'(VIS_COLS) + VRAM_AW'(nCol)) : '0;
  assign rowSel   = nScan;

  always_comb begin
    strb              = '0;
    strb.grabCode     = (sub == SLOT_CODE);
    strb.grabPlane[0] = (sub == SLOT_P0);
    strb.grabPlane[1] = (sub == SLOT_P1);
    strb.loadAll      = (sub == LAST_SUB);
    if (sub == SLOT_P1)  strb.plane = 2'd1;
    if (sub == LAST_SUB) strb.plane = 2'd2;
  end

  assign hsync  = (col >= COL_W'(HS_COL)) && (col < COL_W'(HS_COL + HS_CHARS));
  assign vsync  = (crow == ROW_W'(VS_ROW)) && (scan < SCAN_W'(VS_LINES));
  assign dispEn = (col < COL_W'(VIS_COLS)) && (crow < ROW_W'(VIS_ROWS));

  // R5: hsync begins on the first pixel of its start column
  p_hsync_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> (col == COL_W'(HS_COL) && sub == '0));
  // R6: vsync begins on the first pixel of its start line
  p_vsync_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> (col == '0 && sub == '0 && scan == '0 && crow == ROW_W'(VS_ROW)));
  // R7: the visible window never overlaps a sync pulse
  p_vis_no_sync_r7: assert property (@(posedge clk) disable iff (rst)
    dispEn |-> (!hsync && !vsync));
  // R2: the frame origin is reached only from the last cell of the frame
  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (col == '0 && sub == '0 && scan == '0 && crow == '0) |->
      ($past(col) == LAST_COL && $past(crow) == LAST_ROW));
endmodule

// File: rtl/plane_shifter.sv
`timescale 1ns/1ps
module plane_shifter
  import tile_raster_pkg::*;
#(
  parameter int CELL_W      = 8,
  parameter int CELL_H      = 10,
  parameter int CHAR_STRIDE = 16,
  parameter int PLANE_BYTES = 16384,
  parameter int CODE_W      = 8,
  parameter int TILE_W      = 16,
  localparam int NPLANES    = 3,
  localparam int SCAN_W     = $clog2(CELL_H),
  localparam int ROM_AW     = $clog2(NPLANES * PLANE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  fetch_strobe_t     strb,
  input  logic [SCAN_W-1:0] rowSel,
  input  logic              dispEn,
  input  logic [TILE_W-1:0] vramData,
  input  logic [CELL_W-1:0] romData,
  output logic [ROM_AW-1:0] romAddr,
  output logic [2:0]        pixColour
);
  logic [CODE_W-1:0] codeReg;
  logic [CELL_W-1:0] hold [NPLANES-1];
  logic [CELL_W-1:0] shf  [NPLANES];
  logic              unusedTileBits;

  assign unusedTileBits = ^vramData[TILE_W-1:CODE_W];

  always_ff @(posedge clk) begin
    if (rst)               codeReg <= '0;
    else if (strb.grabCode) codeReg <= vramData[CODE_W-1:0];
  end

  assign romAddr = ROM_AW'(strb.plane) * ROM_AW'(PLANE_BYTES)
                 + ROM_AW'(codeReg) * ROM_AW'(CHAR_STRIDE)
                 + ROM_AW'(rowSel);

  for (genvar g = 0; g < NPLANES; g++) begin : g_plane
    logic [CELL_W-1:0] src;
    if (g < NPLANES - 1) begin : g_held
      always_ff @(posedge clk) begin
        if (rst)                  hold[g] <= '0;
        else if (strb.grabPlane[g]) hold[g] <= romData;
      end
      assign src = hold[g];
    end else begin : g_direct
      assign src = romData;
    end
    always_ff @(posedge clk) begin
      if (rst)              shf[g] <= '0;
      else if (strb.loadAll) shf[g] <= src;
      else                  shf[g] <= {shf[g][CELL_W-2:0], 1'b0};
    end
  end

  assign pixColour = dispEn ? {shf[2][CELL_W-1], shf[1][CELL_W-1], shf[0][CELL_W-1]} : 3'd0;

  // R4: plane bytes are gathered in order before the shifters load
  p_plane_order_r4: assert property (@(posedge clk) disable iff (rst)
    strb.loadAll |-> $past(strb.grabPlane[1]));
  p_plane_seq_r4: assert property (@(posedge clk) disable iff (rst)
    strb.grabPlane[1] |-> $past(strb.grabPlane[0]));
  // R8: the code is captured before the first plane fetch uses it
  p_code_first_r8: assert property (@(posedge clk) disable iff (rst)
    strb.grabPlane[0] |-> $past(strb.grabCode));
endmodule

// File: rtl/tile_raster_gen.sv
`timescale 1ns/1ps
module tile_raster_gen
  import tile_raster_pkg::*;
#(
  parameter int CELL_W      = 8,
  parameter int CELL_H      = 10,
  parameter int VIS_COLS    = 74,
  parameter int VIS_ROWS    = 24,
  parameter int TOT_COLS    = 88,
  parameter int TOT_ROWS    = 27,
  parameter int HS_COL      = 75,
  parameter int HS_CHARS    = 11,
  parameter int VS_ROW      = 25,
  parameter int VS_LINES    = 4,
  parameter int CHAR_STRIDE = 16,
  parameter int PLANE_BYTES = 16384,
  parameter int CODE_W      = 8,
  parameter int TILE_W      = 16,
  localparam int SCAN_W     = $clog2(CELL_H),
  localparam int VRAM_AW    = $clog2(VIS_COLS * VIS_ROWS),
  localparam int ROM_AW     = $clog2(3 * PLANE_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  output logic [VRAM_AW-1:0] vramAddr,
  input  logic [TILE_W-1:0]  vramData,
  output logic [ROM_AW-1:0]  romAddr,
  input  logic [CELL_W-1:0]  romData,
  output logic [2:0]         pixColour,
  output logic               hsync,
  output logic               vsync,
  output logic               dispEn
);
  fetch_strobe_t     strb;
  logic [SCAN_W-1:0] rowSel;

  raster_ctrl #(
    .CELL_W(CELL_W), .CELL_H(CELL_H), .VIS_COLS(VIS_COLS), .VIS_ROWS(VIS_ROWS),
    .TOT_COLS(TOT_COLS), .TOT_ROWS(TOT_ROWS), .HS_COL(HS_COL), .HS_CHARS(HS_CHARS),
    .VS_ROW(VS_ROW), .VS_LINES(VS_LINES)
  ) ctrl_i (
    .clk(clk), .rst(rst), .vramAddr(vramAddr), .strb(strb), .rowSel(rowSel),
    .hsync(hsync), .vsync(vsync), .dispEn(dispEn)
  );

  plane_shifter #(
    .CELL_W(CELL_W), .CELL_H(CELL_H), .CHAR_STRIDE(CHAR_STRIDE),
    .PLANE_BYTES(PLANE_BYTES), .CODE_W(CODE_W), .TILE_W(TILE_W)
  ) data_i (
    .clk(clk), .rst(rst), .strb(strb), .rowSel(rowSel), .dispEn(dispEn),
    .vramData(vramData), .romData(romData), .romAddr(romAddr), .pixColour(pixColour)
  );

  // R1: reset forces every output low
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (pixColour == 3'd0 && !dispEn && !hsync && !vsync));
endmodule

// File: tb/tile_raster_gen_tb_top.sv
`timescale 1ns/1ps
module tile_raster_gen_tb_top;
  localparam int LINE  = 704;
  localparam int LINES = 270;
  localparam int FRAME = LINE * LINES;
  localparam int LAT   = 8;
  localparam int PB    = 16384;
  localparam int NCYC  = LAT + FRAME + 720;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [10:0] vramAddr;
  logic [15:0] vramData;
  logic [15:0] romAddr;
  logic [7:0]  romData;
  logic [2:0]  pixColour;
  logic        hsync, vsync, dispEn;

  logic [15:0] vmem [0:2047];
  logic [7:0]  gmem [0:65535];

  assign vramData = vmem[vramAddr];
  assign romData  = gmem[romAddr];

  tile_raster_gen dut_i (
    .clk(clk), .rst(rst), .vramAddr(vramAddr), .vramData(vramData),
    .romAddr(romAddr), .romData(romData), .pixColour(pixColour),
    .hsync(hsync), .vsync(vsync), .dispEn(dispEn)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      if (nFails <= 40)
        $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference: position p pixels after frame start
  task automatic model(input int p, output int c, output bit d, output bit h, output bit v);
    int pos, x, y, code;
    logic [7:0] b;
    c = 0; d = 0; h = 0; v = 0;
    if (p >= 0) begin
      pos = p % FRAME;
      x = pos % LINE;
      y = pos / LINE;
      d = (x < 592) && (y < 240);
      h = (x / 8 >= 75) && (x / 8 < 86);
      v = (y >= 250) && (y < 254);
      if (d) begin
        code = int'(vmem[(y / 10) * 74 + x / 8][7:0]);
        for (int i = 0; i < 3; i++) begin
          b = gmem[i * PB + code * 16 + y % 10];
          if (b[7 - x % 8]) c = c | (1 << i);
        end
      end
    end
  endtask

  initial begin
    for (int j = 0; j < 65536; j++) gmem[j] = 8'(j * 73 + (j >> 5) * 29 + 11);
    for (int a = 0; a < 2048; a++) vmem[a] = {8'(a * 13 + 90), 8'(a * 7 + 3)};
    for (int a = 1776; a < 2048; a++) vmem[a] = 16'hFFFF;
    // hand-built character 0x42, row 0: colours 3,2,0,0,0,0,4,5
    gmem[0 * PB + 16'h42 * 16] = 8'b1000_0001;
    gmem[1 * PB + 16'h42 * 16] = 8'b1100_0000;
    gmem[2 * PB + 16'h42 * 16] = 8'b0000_0011;
    // unused slot rows 10..15 poisoned (R4)
    for (int r = 10; r < 16; r++)
      for (int i = 0; i < 3; i++) gmem[i * PB + 16'h42 * 16 + r] = 8'hFF;
    // all-ones character 0xFF
    for (int r = 0; r < 16; r++)
      for (int i = 0; i < 3; i++) gmem[i * PB + 16'hFF * 16 + r] = 8'hFF;
    vmem[0]  = 16'hFF42;  // noisy high byte (R8)
    vmem[1]  = 16'h00FF;
    vmem[73] = 16'h3C42;
  end

  initial begin
    int expC, hsRise, lastRise, hsHigh, vsHigh, prevH;
    bit expD, expH, expV;
    int pat [8] = '{3, 2, 0, 0, 0, 0, 4, 5};
    hsRise = 0; lastRise = -1; hsHigh = 0; vsHigh = 0; prevH = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check(pixColour == 3'd0, "R1", "reset colour", int'(pixColour), 0);
    check({dispEn, hsync, vsync} == 3'b000, "R1", "reset de/hs/vs",
          int'({dispEn, hsync, vsync}), 0);
    rst = 1'b0;
    for (int k = 1; k <= NCYC; k++) begin
      int p;
      @(posedge clk);
      @(negedge clk);
      p = k - LAT;
      model(p, expC, expD, expH, expV);
      // per-cycle comparison: colour covers R3/R4/R8, de R7, syncs R5/R6
      check(int'(pixColour) == expC, (p < 0) ? "R1" : "R3", "colour", int'(pixColour), expC);
      check(dispEn == expD, "R7", "dispEn", int'(dispEn), int'(expD));
      check(hsync == expH, "R5", "hsync", int'(hsync), int'(expH));
      check(vsync == expV, "R6", "vsync", int'(vsync), int'(expV));
      if (p >= 0 && p < 8)
        check(int'(pixColour) == pat[p], "R3", "hand cell pixel", int'(pixColour), pat[p]);
      if (p >= 8 && p < 16)
        check(pixColour == 3'd7, "R3", "all-ones cell", int'(pixColour), 7);
      if (p == 0)
        check(dispEn == 1'b1, "R1", "first pixel visible after 8 edges", int'(dispEn), 1);
      if (p == FRAME)
        check(pixColour == 3'd3, "R2", "next frame origin", int'(pixColour), 3);
      if (p >= 0 && p < FRAME) begin
        if (hsync && !prevH) begin
          if (lastRise >= 0)
            check(p - lastRise == LINE, "R2", "hsync spacing", p - lastRise, LINE);
          lastRise = p;
          hsRise++;
        end
        if (hsync) hsHigh++;
        if (vsync) vsHigh++;
      end
      prevH = int'(hsync);
    end
    check(hsRise == LINES, "R2", "lines per frame", hsRise, LINES);
    check(hsHigh == LINES * 88, "R5", "hsync clocks per frame", hsHigh, LINES * 88);
    check(vsHigh == 4 * LINE, "R6", "vsync clocks per frame", vsHigh, 4 * LINE);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 199500);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule